// File: doc/BRIEF.md
# Inter-Processor Doorbell Controller

This block passes numbered doorbell signals between processors. Software on the local processor rings a doorbell by writing one 32-bit identifier that names a remote client and a signal of that client. Signals arriving from other processors come in as single-cycle pulses on a line vector. Each pulse is latched as pending for its client/signal entry. Each entry also has its own receive-enable bit.

Software services incoming signals by identifier and not by bitmask. It reads the receive register to get the identifier of the next pending, enabled signal. It then writes that same identifier to the clear register and repeats until the receive register returns all ones. Enable, disable, single-signal clear and whole-client clear are all written in the same identifier form. A single active-high, level-sensitive interrupt stays asserted while any enabled signal is pending.

The register bus is plain: a write strobe with address and data, and a read path that decodes the address combinationally. The outgoing doorbell is a one-cycle strobe with no ready, so it is never back-pressured. A receiver that cannot accept it must latch it, which the pending logic of a peer controller does. Incoming lines are pulses with no handshake either.

Top module: `ipc_doorbell_ctrl`

## Requirements
- R1: An identifier holds the client number in bits 31:16 and the signal number in bits 15:0. The entry index is client*NUM_SIG+signal. With the defaults there are 4 clients, 4 signals per client and 16 entries.
- R2: A write to offset 0x0C with a valid identifier drives `db_valid` high for exactly the next cycle, with `db_client` and `db_signal` equal to the decoded fields.
- R3: Reading offset 0x10 returns the identifier of the pending, enabled entry with the lowest client number, and within that client the lowest signal number. It returns 0xFFFFFFFF when there is none. Other offsets read as zero.
- R4: A write of an identifier to 0x14 enables that entry, and a write to 0x18 disables it. Its pending state is left as it was.
- R5: A write of an identifier to 0x1C clears that entry's pending state.
- R6: A write to 0x38 whose whole 32-bit value is a client number below NUM_CLIENT clears the pending state of every signal of that client. Other clients are left unchanged.
- R7: `irq` is high exactly while at least one entry is both pending and enabled.
- R8: A pulse on a disabled entry still latches it as pending. The entry stays hidden from 0x10 and from `irq` until it is enabled.
- R9: Any write whose client or signal field is out of range has no effect: no strobe, and no change to pending or enable state. This covers the 0x38 write as well.
- R10: If an incoming pulse and a clear of the same entry land in the same cycle, the entry ends up pending.
- R11: Reset clears all pending and enable bits. After reset, 0x10 reads 0xFFFFFFFF, `irq` is low and `db_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current `bus_addr` |
| sig_in | input | NUM_CLIENT*NUM_SIG | Incoming signal pulses, one per entry |
| irq | output | 1 | Summary interrupt, level, active high |
| db_valid | output | 1 | Outgoing doorbell strobe |
| db_client | output | clog2(NUM_CLIENT) | Target client of the strobe |
| db_signal | output | clog2(NUM_SIG) | Target signal of the strobe |

## Verification
The bench loops the outgoing strobe back into the incoming lines and then targets several corner cases:
- A pulse on a disabled entry. A design that drops it would lose the signal once the entry is later enabled.
- A pulse that lands in the same cycle as a clear of that entry. A design that lets the clear win would lose a doorbell.
- Several entries pending at once. Here the lowest-identifier rule shows whether the priority order is reversed.
- Out-of-range identifiers and client-wide clears. These expose a decoder that aliases high bits onto valid entries.

A behavioural model is compared with the design on every cycle under random traffic.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam logic [7:0] OFF_SEND   = 8'h0C;
  localparam logic [7:0] OFF_RECV   = 8'h10;
  localparam logic [7:0] OFF_EN     = 8'h14;
  localparam logic [7:0] OFF_DIS    = 8'h18;
  localparam logic [7:0] OFF_CLR    = 8'h1C;
  localparam logic [7:0] OFF_CCLR   = 8'h38;
  localparam logic [31:0] ID_NONE   = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    OP_NONE, OP_SEND, OP_EN, OP_DIS, OP_CLR, OP_CCLR
  } wr_op_e;
endpackage

// File: rtl/ipc_wr_decode.sv
module ipc_wr_decode
  import ipc_pkg::*;
#(
  parameter int NUM_CLIENT = 4,
  parameter int NUM_SIG    = 4,
  localparam int N  = NUM_CLIENT * NUM_SIG,
  localparam int CW = (NUM_CLIENT > 1) ? $clog2(NUM_CLIENT) : 1,
  localparam int SW = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1
) (
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [N-1:0]  en_set,
  output logic [N-1:0]  en_clr,
  output logic [N-1:0]  pend_clr,
  output logic          send_v,
  output logic [CW-1:0] send_c,
  output logic [SW-1:0] send_s
);
  wr_op_e      op;
  logic [15:0] f_client;
  logic [15:0] f_sig;
  logic        id_ok;
  logic        cc_ok;
  logic [N-1:0] id_hot;
  logic [N-1:0] cc_hot;

  assign f_client = wdata[31:16];
  assign f_sig    = wdata[15:0];
  assign id_ok    = (f_client < 16'(NUM_CLIENT)) && (f_sig < 16'(NUM_SIG));
  assign cc_ok    = wdata < 32'(NUM_CLIENT);

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      case (addr)
        OFF_SEND: op = OP_SEND;
        OFF_EN:   op = OP_EN;
        OFF_DIS:  op = OP_DIS;
        OFF_CLR:  op = OP_CLR;
        OFF_CCLR: op = OP_CCLR;
        default:  op = OP_NONE;
      endcase
    end
  end

  genvar gc, gs;
  generate
    for (gc = 0; gc < NUM_CLIENT; gc++) begin : g_cli
      for (gs = 0; gs < NUM_SIG; gs++) begin : g_sig
        assign id_hot[gc*NUM_SIG+gs] = id_ok && (f_client == 16'(gc)) && (f_sig == 16'(gs));
        assign cc_hot[gc*NUM_SIG+gs] = cc_ok && (wdata == 32'(gc));
      end
    end
  endgenerate

  assign en_set   = (op == OP_EN)  ? id_hot : '0;
  assign en_clr   = (op == OP_DIS) ? id_hot : '0;
  assign pend_clr = (op == OP_CLR) ? id_hot : ((op == OP_CCLR) ? cc_hot : '0);
  assign send_v   = (op == OP_SEND) && id_ok;
  assign send_c   = f_client[CW-1:0];
  assign send_s   = f_sig[SW-1:0];
endmodule

// File: rtl/ipc_entry_bank.sv
module ipc_entry_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  input  logic [N-1:0] en_set,
  input  logic [N-1:0] en_clr,
  input  logic [N-1:0] pend_clr,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] en_q,
  output logic         any_live
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q[gi] <= 1'b0;
          en_q[gi]   <= 1'b0;
        end else begin
          pend_q[gi] <= sig_in[gi] | (pend_q[gi] & ~pend_clr[gi]);
          en_q[gi]   <= en_set[gi] | (en_q[gi] & ~en_clr[gi]);
        end
      end
    end
  endgenerate

  assign any_live = |(pend_q & en_q);
endmodule

// File: rtl/ipc_lowest_pick.sv
module ipc_lowest_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  live,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ipc_doorbell_ctrl.sv
module ipc_doorbell_ctrl
  import ipc_pkg::*;
#(
  parameter int NUM_CLIENT = 4,
  parameter int NUM_SIG    = 4,
  localparam int N  = NUM_CLIENT * NUM_SIG,
  localparam int CW = (NUM_CLIENT > 1) ? $clog2(NUM_CLIENT) : 1,
  localparam int SW = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [N-1:0]  sig_in,
  output logic          irq,
  output logic          db_valid,
  output logic [CW-1:0] db_client,
  output logic [SW-1:0] db_signal
);
  logic [N-1:0]  en_set, en_clr, pend_clr;
  logic [N-1:0]  pend_q, en_q;
  logic          send_v;
  logic [CW-1:0] send_c;
  logic [SW-1:0] send_s;
  logic          pick_valid;
  logic [IW-1:0] pick_idx;
  logic          any_live;

  ipc_wr_decode #(.NUM_CLIENT(NUM_CLIENT), .NUM_SIG(NUM_SIG)) u_dec (
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .en_set(en_set), .en_clr(en_clr), .pend_clr(pend_clr),
    .send_v(send_v), .send_c(send_c), .send_s(send_s)
  );

  ipc_entry_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .en_set(en_set), .en_clr(en_clr), .pend_clr(pend_clr),
    .pend_q(pend_q), .en_q(en_q), .any_live(any_live)
  );

  ipc_lowest_pick #(.N(N)) u_pick (
    .live(pend_q & en_q), .found(pick_valid), .idx(pick_idx)
  );

  assign irq = any_live;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_RECV) begin
      if (pick_valid)
        bus_rdata = {16'(int'(pick_idx) / NUM_SIG), 16'(int'(pick_idx) % NUM_SIG)};
      else
        bus_rdata = ID_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_valid  <= 1'b0;
      db_client <= '0;
      db_signal <= '0;
    end else begin
      db_valid <= send_v;
      if (send_v) begin
        db_client <= send_c;
        db_signal <= send_s;
      end
    end
  end
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic [N-1:0]  sig_in,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  en_q,
  input logic          irq,
  input logic          pick_valid,
  input logic [IW-1:0] pick_idx,
  input logic          db_valid
);
  AST_IRQ_AGREES_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq == pick_valid); // R7
  AST_PICK_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (pend_q[pick_idx] && en_q[pick_idx])); // R8
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> ((pend_q & en_q & ((N'(1) << pick_idx) - N'(1))) == '0)); // R3
  AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(sig_in)) == $past(sig_in))); // R10
  AST_NO_PHANTOM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(sig_in)) == '0)); // R5
  AST_STROBE_FROM_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> $past(bus_wr && bus_addr == 8'h0C)); // R2
endmodule

bind ipc_doorbell_ctrl ipc_doorbell_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .sig_in(sig_in), .pend_q(pend_q), .en_q(en_q), .irq(irq),
  .pick_valid(pick_valid), .pick_idx(pick_idx), .db_valid(db_valid)
);

// File: tb/tb_ipc_doorbell_ctrl.sv
module tb_ipc_doorbell_ctrl;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int N  = NC * NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] drv_sig = '0;
  logic [N-1:0] loop_sig;
  logic [N-1:0] sig_in;
  logic        irq, db_valid;
  logic [1:0]  db_client, db_signal;

  int errors = 0;
  int checks = 0;

  // reference state
  bit m_pend [N];
  bit m_en   [N];
  bit m_dbv;
  int m_dbc, m_dbs;

  always #5 clk = ~clk;

  assign loop_sig = db_valid ? (N'(1) << (int'(db_client) * NS + int'(db_signal))) : '0;
  assign sig_in   = drv_sig | loop_sig;

  ipc_doorbell_ctrl #(.NUM_CLIENT(NC), .NUM_SIG(NS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sig_in(sig_in),
    .irq(irq), .db_valid(db_valid), .db_client(db_client), .db_signal(db_signal)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_en[i] = 0; end
      m_dbv = 0; m_dbc = 0; m_dbs = 0;
    end else begin
      int c, s, k;
      bit ok;
      c  = int'(bus_wdata[31:16]);
      s  = int'(bus_wdata[15:0]);
      ok = (c < NC) && (s < NS);
      k  = c * NS + s;
      if (bus_wr && ok && bus_addr == 8'h1C) m_pend[k] = 0;
      if (bus_wr && bus_addr == 8'h38 && bus_wdata < NC)
        for (int j = 0; j < NS; j++) m_pend[int'(bus_wdata) * NS + j] = 0;
      for (int i = 0; i < N; i++) if (sig_in[i]) m_pend[i] = 1;
      if (bus_wr && ok && bus_addr == 8'h14) m_en[k] = 1;
      if (bus_wr && ok && bus_addr == 8'h18) m_en[k] = 0;
      m_dbv = bus_wr && ok && bus_addr == 8'h0C;
      if (m_dbv) begin m_dbc = c; m_dbs = s; end
    end
  end

  function automatic logic [31:0] exp_rdata(logic [7:0] a);
    if (a != 8'h10) return 32'h0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i]) return {16'(i / NS), 16'(i % NS)};
    return 32'hFFFF_FFFF;
  endfunction

  function automatic bit exp_irq();
    for (int i = 0; i < N; i++) if (m_pend[i] && m_en[i]) return 1;
    return 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply inputs for one cycle, compare against the model, advance.
  task automatic step(string tag, bit wr, logic [7:0] a, logic [31:0] d, logic [N-1:0] p);
    bus_wr = wr; bus_addr = a; bus_wdata = d; drv_sig = p;
    #1;
    check({tag, " rdata"}, bus_rdata, exp_rdata(a));
    check({tag, " irq"}, 32'(irq), 32'(exp_irq()));
    check({tag, " db_valid"}, 32'(db_valid), 32'(m_dbv));
    if (m_dbv) begin
      check({tag, " db_client"}, 32'(db_client), 32'(m_dbc));
      check({tag, " db_signal"}, 32'(db_signal), 32'(m_dbs));
    end
    @(negedge clk);
  endtask

  task automatic peek(string tag, logic [31:0] exp_rd, bit exp_i);
    bus_wr = 0; bus_addr = 8'h10; drv_sig = '0;
    #1;
    check({tag, " literal rdata"}, bus_rdata, exp_rd);
    check({tag, " literal irq"}, 32'(irq), 32'(exp_i));
    step(tag, 0, 8'h10, 0, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    peek("R11", 32'hFFFF_FFFF, 0);
    checks++; if (db_valid !== 1'b0) begin errors++; $display("FAIL R11: actual=%b expected=0", db_valid); end

    // R4 enable then R2 send with loopback, R1 identifier layout
    step("R4", 1, 8'h14, 32'h0002_0001, '0);
    step("R2", 1, 8'h0C, 32'h0002_0001, '0);
    checks++; if (!(db_valid && db_client == 2 && db_signal == 1)) begin
      errors++; $display("FAIL R2: actual=%b/%0d/%0d expected=1/2/1", db_valid, db_client, db_signal); end
    step("R2", 0, 8'h10, 0, '0);
    checks++; if (db_valid !== 1'b0) begin errors++; $display("FAIL R2: actual=%b expected=0", db_valid); end
    peek("R1", 32'h0002_0001, 1);

    // R8 disabled entry latches but is hidden
    step("R8", 0, 8'h10, 0, N'(1));
    peek("R8", 32'h0002_0001, 1);
    step("R3", 1, 8'h14, 32'h0000_0000, '0);
    peek("R3", 32'h0000_0000, 1);

    // R5 clear by identifier, loop until empty (R7)
    step("R5", 1, 8'h1C, 32'h0000_0000, '0);
    peek("R5", 32'h0002_0001, 1);
    step("R5", 1, 8'h1C, 32'h0002_0001, '0);
    peek("R7", 32'hFFFF_FFFF, 0);

    // R9 out-of-range writes ignored
    step("R9", 1, 8'h14, 32'h0004_0000, '0);
    step("R9", 1, 8'h0C, 32'h0000_0004, '0);
    checks++; if (db_valid !== 1'b0) begin errors++; $display("FAIL R9: actual=%b expected=0", db_valid); end
    step("R9", 0, 8'h10, 0, '1);
    peek("R9", 32'h0000_0000, 1);
    step("R9", 1, 8'h38, 32'h0000_0004, '0);
    peek("R9", 32'h0000_0000, 1);

    // R6 client-wide clear of client 0
    step("R6", 1, 8'h38, 32'h0000_0000, '0);
    peek("R6", 32'h0002_0001, 1);

    // R10 pulse and clear on the same entry in one cycle
    step("R10", 1, 8'h1C, 32'h0002_0001, N'(1) << 9);
    peek("R10", 32'h0002_0001, 1);

    // R4 disable hides, re-enable restores
    step("R4", 1, 8'h18, 32'h0002_0001, '0);
    peek("R4", 32'hFFFF_FFFF, 0);
    step("R4", 1, 8'h14, 32'h0002_0001, '0);
    peek("R4", 32'h0002_0001, 1);

    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      int pick;
      pick = int'($urandom_range(0, 6));
      case (pick)
        0: a = 8'h0C; 1: a = 8'h14; 2: a = 8'h18; 3: a = 8'h1C;
        4: a = 8'h38; 5: a = 8'h10; default: a = 8'h20;
      endcase
      d = (a == 8'h38) ? 32'($urandom_range(0, 4))
                       : {16'($urandom_range(0, 4)), 16'($urandom_range(0, 4))};
      step("R3", $urandom_range(0, 1) == 1, a,  d,
           ($urandom_range(0, 3) == 0) ? N'($urandom) : '0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule